// File: doc/BRIEF.md
# Serial Shift LED Output Controller

The controller drives 32 output bits (LEDs or output-only general-purpose pins) onto an external chain of shift registers, using three wires: serial data, shift clock and a store strobe. Software programs it through a small word-addressed register bus. The bus reaches two control words, an output-data word, a per-pin blink mask and a per-pin mask that hands a pin to a hardware input.

A transfer can be started in three ways. One is a one-shot software request. The other two are periodic ticks, which come either from an external timer or from an internal divider of the core clock. When a transfer starts, the controller freezes the output values in a shadow word. It then shifts the enabled groups of eight pins out, highest pin first, at the selected shift-clock rate. A one-cycle store strobe follows the last bit. Pins set in the blink mask are inverted on alternate periodic ticks.

Top module: `serial_led_shifter`

## Requirements
- R1: After reset every register reads 0 and the outputs are idle: ser_data 0, ser_clk 0, ser_store 0.
- R2: Word addresses are 0 for control 0, 1 for control 1, 2 for output data, 3 for the blink mask and 4 for the hardware mask. Other addresses read 0. Bit 31 of control 0 always reads 0.
- R3: Writing control 0 with bit 31 set while control 1 bits 31:30 equal 0 requests one transfer. The request stays pending until a transfer starts, which is the cycle after the request if the engine is idle. With any other source value the write's bit 31 has no effect.
- R4: Bits 3:0 of control 1 enable pin groups 0–7, 8–15, 16–23 and 24–31 (bit n enables group n). Only enabled groups are sent, starting at the highest pin of the highest enabled group and going downward. If no group is enabled, a trigger causes no activity.
- R5: Control 1 bits 21:20 (code c) set the bit period to 8·2^c core cycles. Bit c is captured when the transfer starts. ser_data presents each bit for the whole period, and the sampling edge of ser_clk falls at the middle of the period.
- R6: With control 0 bit 26 equal to 0, ser_clk idles low and rises at mid-bit. With the bit equal to 1, ser_clk idles high and falls at mid-bit.
- R7: ser_store is high for exactly one core cycle, in the cycle right after the last bit period. It never appears without a preceding transfer.
- R8: With control 0 bit 30 set and source 1, each cycle with ext_tick high starts a transfer if the engine is idle. Ticks that arrive while a transfer or strobe is in progress are dropped.
- R9: With control 0 bit 30 set and source 2, an internal tick occurs every 4000, 2000, 1000 or 800 core cycles for control 1 bits 24:23 codes 0 to 3. The first tick comes that many cycles after the mode is entered.
- R10: A pin whose blink bit is set sends its data bit XOR the blink phase. The phase resets to 0 and toggles on every periodic tick, including dropped ones. A transfer started by a tick uses the phase from before that tick's toggle.
- R11: A pin whose hardware-mask bit is set sends hw_val at that pin, sampled when the transfer starts, instead of data and blink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ext_tick | input | 1 | Periodic tick from an external timer |
| hw_val | input | 32 | Pin values for hardware-controlled pins |
| ser_data | output | 1 | Serial data to the chain |
| ser_clk | output | 1 | Shift clock |
| ser_store | output | 1 | Store strobe to the chain |

## Verification
Register writes take effect at the next edge. A trigger seen in an idle cycle puts the first bit on ser_data from the following edge. Each bit then lasts 8·2^c cycles, with the clock edge at its midpoint, and the strobe occupies the single cycle after the last period. The bench model advances on the same edges with a queue of expected bits and a position-in-bit count. Between edges it compares ser_data, ser_clk and ser_store with the model in every cycle. Strobe counts over fixed windows check the dropped ticks, the ignored requests and the internal tick spacing.

// File: rtl/serial_led_shifter.sv
module serial_led_shifter #(
  parameter int DIV0 = 4000,
  parameter int DIV1 = 2000,
  parameter int DIV2 = 1000,
  parameter int DIV3 = 800,
  parameter int DIV_W = 16,
  parameter int HALF_MIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ext_tick,
  input  logic [31:0] hw_val,
  output logic        ser_data,
  output logic        ser_clk,
  output logic        ser_store
);
  localparam int HW = 8;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_STORE} st_t;

  st_t st;
  logic [31:0] ctrl0, ctrl1, dout, blink, hwsel, shadow;
  logic pend, phase, hclk;
  logic [1:0] grp;
  logic [2:0] bitn;
  logic [3:0] gq;
  logic [HW-1:0] hcnt, half_q;
  logic [DIV_W-1:0] divcnt, div_lim;
  logic shifting, edge_sel;

  function automatic logic [2:0] below(input logic [3:0] m, input int from);
    logic [2:0] r;
    r = '0;
    for (int i = 0; i < 4; i++)
      if (i < from && m[i]) r = {1'b1, 2'(i)};
    return r;
  endfunction

  always_comb
    case (ctrl1[24:23])
      2'd0: div_lim = DIV_W'(DIV0 - 1);
      2'd1: div_lim = DIV_W'(DIV1 - 1);
      2'd2: div_lim = DIV_W'(DIV2 - 1);
      default: div_lim = DIV_W'(DIV3 - 1);
    endcase

  wire [1:0]  src     = ctrl1[31:30];
  wire        auto_en = ctrl0[30];
  wire        int_run = auto_en && src == 2'd2;
  wire        div_tick = int_run && divcnt == div_lim;
  wire        tick    = auto_en && ((src == 2'd1 && ext_tick) || div_tick);
  wire        idle    = st == S_IDLE;
  wire        go      = idle && (pend || tick);
  wire        sw_req  = bus_wr && bus_addr == 3'd0 && bus_wdata[31] && src == 2'd0;
  wire [31:0] pin_val = (hwsel & hw_val) | (~hwsel & (dout ^ (blink & {32{phase}})));
  wire [2:0]  top     = below(ctrl1[3:0], 4);
  wire [2:0]  nxt     = below(gq, int'(grp));
  wire        half_end = hcnt == half_q - HW'(1);

  assign shifting  = st == S_SHIFT;
  assign edge_sel  = ctrl0[26];
  assign ser_data  = shifting && shadow[{grp, bitn}];
  assign ser_clk   = hclk ^ edge_sel;
  assign ser_store = st == S_STORE;

  always_comb
    case (bus_addr)
      3'd0: bus_rdata = ctrl0;
      3'd1: bus_rdata = ctrl1;
      3'd2: bus_rdata = dout;
      3'd3: bus_rdata = blink;
      3'd4: bus_rdata = hwsel;
      default: bus_rdata = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ctrl0 <= '0; ctrl1 <= '0; dout <= '0; blink <= '0; hwsel <= '0;
      shadow <= '0; pend <= 1'b0; phase <= 1'b0; hclk <= 1'b0;
      grp <= '0; bitn <= '0; gq <= '0; hcnt <= '0; half_q <= '0;
      divcnt <= '0;
    end else begin
      if (bus_wr)
        case (bus_addr)
          3'd0: ctrl0 <= {1'b0, bus_wdata[30:0]};
          3'd1: ctrl1 <= bus_wdata;
          3'd2: dout  <= bus_wdata;
          3'd3: blink <= bus_wdata;
          3'd4: hwsel <= bus_wdata;
          default: ;
        endcase
      if (sw_req) pend <= 1'b1;
      else if (idle) pend <= 1'b0;
      if (tick) phase <= ~phase;
      if (!int_run || div_tick) divcnt <= '0;
      else divcnt <= divcnt + DIV_W'(1);
      case (st)
        S_IDLE:
          if (go && top[2]) begin
            st <= S_SHIFT;
            shadow <= pin_val;
            gq <= ctrl1[3:0];
            grp <= top[1:0];
            bitn <= 3'd7;
            hcnt <= '0;
            hclk <= 1'b0;
            half_q <= HW'(HALF_MIN) << ctrl1[21:20];
          end
        S_SHIFT:
          if (half_end) begin
            hcnt <= '0;
            hclk <= ~hclk;
            if (hclk) begin
              if (bitn != 3'd0) bitn <= bitn - 3'd1;
              else if (nxt[2]) begin
                grp <= nxt[1:0];
                bitn <= 3'd7;
              end else st <= S_STORE;
            end
          end else hcnt <= hcnt + HW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module serial_led_shifter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        ser_data,
  input logic        ser_clk,
  input logic        ser_store,
  input logic        shifting,
  input logic        edge_sel
);
  // R2
  rd_req_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 3'd0 |-> !bus_rdata[31]);
  // R7
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_store |=> !ser_store);
  // R7
  store_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_store |-> $past(shifting));
  // R6
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> (ser_clk == edge_sel && !ser_data));
endmodule

bind serial_led_shifter serial_led_shifter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .ser_data(ser_data), .ser_clk(ser_clk), .ser_store(ser_store),
  .shifting(shifting), .edge_sel(edge_sel)
);

// File: tb/serial_led_shifter_tb_top.sv
`timescale 1ns/1ps
module serial_led_shifter_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, hw_val = 0;
  logic ext_tick = 0;
  logic [31:0] bus_rdata;
  logic ser_data, ser_clk, ser_store;

  always #5 clk = ~clk;

  serial_led_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
    .hw_val(hw_val), .ser_data(ser_data), .ser_clk(ser_clk), .ser_store(ser_store)
  );

  int n_chk = 0, n_fail = 0, n_store = 0, wd = 0;
  int divs[4] = '{4000, 2000, 1000, 800};

  logic [31:0] m_c0, m_c1, m_dat, m_blk, m_hw;
  logic m_pend, m_phase, m_busy, m_store;
  int m_div, m_t, m_half;
  bit m_q[$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c0 = 0; m_c1 = 0; m_dat = 0; m_blk = 0; m_hw = 0;
      m_pend = 0; m_phase = 0; m_busy = 0; m_store = 0;
      m_div = 0; m_t = 0; m_half = 4; m_q.delete();
    end else begin
      bit auto_on, irun, dtick, tk, go;
      logic [31:0] v;
      auto_on = m_c0[30];
      irun = auto_on && m_c1[31:30] == 2;
      dtick = irun && m_div == divs[m_c1[24:23]] - 1;
      tk = auto_on && ((m_c1[31:30] == 1 && ext_tick) || dtick);
      go = !m_busy && !m_store && (m_pend || tk);
      if (m_store) m_store = 0;
      else if (m_busy) begin
        m_t++;
        if (m_t == 2 * m_half) begin
          m_t = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin m_busy = 0; m_store = 1; end
        end
      end else if (go) begin
        v = (m_hw & hw_val) | (~m_hw & (m_dat ^ (m_blk & {32{m_phase}})));
        for (int g = 3; g >= 0; g--)
          if (m_c1[g])
            for (int b = 7; b >= 0; b--) m_q.push_back(v[g*8+b]);
        m_busy = m_q.size() > 0;
        m_t = 0;
        m_half = 4 << m_c1[21:20];
      end
      if (bus_wr && bus_addr == 0 && bus_wdata[31] && m_c1[31:30] == 0) m_pend = 1;
      else if (go) m_pend = 0;
      if (tk) m_phase = !m_phase;
      m_div = (!irun || dtick) ? 0 : m_div + 1;
      if (bus_wr)
        case (bus_addr)
          0: m_c0 = bus_wdata & 32'h7fff_ffff;
          1: m_c1 = bus_wdata;
          2: m_dat = bus_wdata;
          3: m_blk = bus_wdata;
          4: m_hw = bus_wdata;
          default: ;
        endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic es, ec;
    es = m_busy ? m_q[0] : 1'b0;
    ec = (m_busy && m_t >= m_half) ^ m_c0[26];
    // R4 R11 R10 bit order and values, R5 R6 clock timing, R7 strobe
    check(ser_data == es, "R4 ser_data", 32'(ser_data), 32'(es));
    check(ser_clk == ec, "R5 ser_clk", 32'(ser_clk), 32'(ec));
    check(ser_store == m_store, "R7 ser_store", 32'(ser_store), 32'(m_store));
    if (ser_store) n_store++;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; #1;
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk); ext_tick = 1;
    @(negedge clk); ext_tick = 0;
  endtask

  task automatic wait_idle();
    while (m_busy || m_store || m_pend) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      check(0, "watchdog", 32'(wd), 0);
      finish_run();
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ser_data == 0 && ser_clk == 0 && ser_store == 0, "R1 idle outputs",
          {ser_data, ser_clk, ser_store}, 0);
    for (int a = 0; a < 5; a++) rd(3'(a), 0, "R1 reset reg");
    rst_n = 1;
    @(negedge clk);

    // R2 readback
    wr(2, 32'hA5C3_0F96);
    wr(1, 32'h0000_000F);
    wr(3, 32'h1234_5678); rd(3, 32'h1234_5678, "R2 blink readback");
    wr(3, 0);
    rd(2, 32'hA5C3_0F96, "R2 data readback");
    rd(1, 32'h0000_000F, "R2 ctrl1 readback");
    rd(5, 0, "R2 unused address");

    // R3 software request, all groups, code 0
    s0 = n_store;
    wr(0, 32'h8000_0000);
    rd(0, 0, "R3 request bit reads 0");
    wait_idle();
    check(n_store - s0 == 1, "R3 one strobe", 32'(n_store - s0), 1);

    // R4 R5 R6 groups 0 and 2, code 1, falling edge
    wr(1, 32'h0010_0005);
    wr(0, 32'h0400_0000);
    wr(0, 32'h8400_0000);
    wait_idle();

    // R4 no group enabled: no activity
    s0 = n_store;
    wr(1, 32'h0000_0000);
    wr(0, 32'h8000_0000);
    repeat (100) @(negedge clk);
    check(n_store == s0, "R4 no groups no strobe", 32'(n_store - s0), 0);

    // R3 request ignored with a periodic source selected
    wr(0, 0);
    wr(1, 32'h4000_0001);
    s0 = n_store;
    wr(0, 32'h8000_0000);
    repeat (200) @(negedge clk);
    check(n_store == s0, "R3 ignored with source 1", 32'(n_store - s0), 0);

    // R8 R10 external ticks, blink low byte
    wr(2, 32'h0000_000F);
    wr(3, 32'h0000_00FF);
    wr(0, 32'h4000_0000);
    s0 = n_store;
    pulse_tick();
    repeat (10) @(negedge clk);
    pulse_tick();
    wait_idle();
    pulse_tick();
    wait_idle();
    check(n_store - s0 == 2, "R8 busy tick dropped", 32'(n_store - s0), 2);
    pulse_tick();
    wait_idle();

    // R9 internal divider code 3 (800 cycles)
    wr(0, 0);
    wr(1, 32'h8180_0001);
    s0 = n_store;
    wr(0, 32'h4000_0000);
    repeat (2000) @(negedge clk);
    wr(0, 0);
    check(n_store - s0 == 2, "R9 internal ticks in window", 32'(n_store - s0), 2);
    wait_idle();

    // R11 hardware-controlled pins
    wr(3, 0);
    wr(1, 32'h0000_000F);
    wr(2, 32'h0FF0_0FF0);
    wr(4, 32'hF000_000F);
    hw_val = 32'h5000_000A;
    rd(4, 32'hF000_000F, "R11 hw mask readback");
    wr(0, 32'h8000_0000);
    wait_idle();

    finish_run();
  end
endmodule